// File: doc/BRIEF.md
# Programmable Word Delay Line

This block passes a stream of 16-bit words through a circular buffer and returns each word a programmed number of clock cycles later. The delay is always even: twice an 11-bit setting plus two. A setting of 0 gives the shortest delay of 2 clocks, a setting of 2 gives 6 clocks, and the largest setting gives 4096 clocks. A word is accepted on every rising clock edge, and one word is produced on every rising clock edge.

A host loads the setting by presenting it on `dly_val`, driving `cs_n` low, and pulling `ds_n` low. The block samples the strobe synchronously and captures the value when it sees a falling strobe while the chip select is low. A captured value does not take effect at once. It waits for the start of the next two-clock channel. The frame pulse only re-aligns that channel phase. It never clears the buffer, the pointers or the delay. After reset, and after every change of delay, the output reads zero until the buffer holds enough words written under the new setting.

Top module: `wdl_top`

## Requirements
- R1: While `rst` is high, and on the clock edge that ends it, `dout` is zero. After reset the setting is 0, which gives a delay of 2 clocks.
- R2: With delay D = 2*V+2, where V is the applied setting, the word sampled from `din` at rising edge n is on `dout` after rising edge n+D. This holds for every V from 0 to 2047.
- R3: A setting is captured at a rising edge that samples `ds_n` low, `cs_n` low and `ds_n` high at the previous edge. The value captured is `dly_val[10:0]`. A strobe with `cs_n` high is ignored, and a strobe held low captures only once.
- R4: The channel phase is 0 on the first edge after reset and flips at every edge. The edge after one that samples `frame_n` low always has phase 0. A captured setting is applied at the first later edge that has phase 0.
- R5: On the edge where a new setting is applied, `dout` becomes zero. It stays zero until D words have been written from that edge on, so that it is nonzero only after edge r+D, where r is the apply edge.
- R6: Pulses on `frame_n` leave the delay, the buffer and the output stream unchanged.
- R7: The largest setting, 2047, gives a delay of exactly 4096 clocks, and the next largest setting, 2046, gives 4094 clocks.
- R8: A capture that falls on the same edge as a pending apply wins. The pending setting is discarded, and only the newer value is applied, at the next phase-0 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data enters and leaves on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select for setting capture, active low |
| ds_n | input | 1 | Data strobe; its falling edge captures the setting |
| frame_n | input | 1 | Frame pulse, active low; re-aligns the channel phase |
| dly_val | input | 11 | Delay setting V; delay is 2*V+2 clocks |
| din | input | 16 | Input word stream |
| dout | output | 16 | Delayed word stream, registered |

## Verification
A word sampled at edge n is due after edge n+D. A strobe sampled at edge c takes effect at the first phase-0 edge after c, and that edge drives `dout` to zero. The bench replays every applied input through a behavioural model: a history queue indexed by edge number, plus its own phase, pending flag and apply edge. It compares `dout` at the falling edge that follows each rising edge, so the output of edge n is compared with the model's value for edge n. The input is a counting pattern that never equals zero, so a word one place early or late, or a blank window one edge too long or too short, shows up as a miscompare.

// File: rtl/wdl_pkg.sv
package wdl_pkg;

    parameter int unsigned VAL_W  = 11;
    parameter int unsigned DATA_W = 16;

    // The buffer must hold the longest delay: 2*(2^VAL_W - 1) + 2 = 2^(VAL_W+1).
    localparam int unsigned AW    = VAL_W + 1;
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned SPN_W = VAL_W + 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [VAL_W-1:0]  val_t;
    typedef logic [AW-1:0]     addr_t;
    typedef logic [SPN_W-1:0]  span_t;

    typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;

    typedef struct packed {
        logic  apply;
        span_t span;
    } load_cmd_t;

    typedef struct packed {
        logic  ok;
        addr_t wr;
        addr_t rd;
    } ptr_t;

    function automatic span_t span_of(val_t v);
        return span_t'({1'b0, v, 1'b0}) + span_t'(2);
    endfunction

    function automatic phase_e next_phase(phase_e p, logic frame_low);
        if (frame_low) return PH_EVEN;
        return (p == PH_EVEN) ? PH_ODD : PH_EVEN;
    endfunction

endpackage

// File: rtl/wdl_load_ctl.sv
module wdl_load_ctl
    import wdl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      ds_n,
    input  logic      frame_n,
    input  val_t      val_in,
    output logic      cap,
    output logic      pend,
    output load_cmd_t cmd
);

    logic   ds_q;
    phase_e phase;
    val_t   pval;
    span_t  span_q;
    logic   apply;

    // Strobe fall sampled at a clock edge while selected.
    assign cap   = ds_q & ~ds_n & ~cs_n;
    // A newer capture on the same edge defers the apply.
    assign apply = pend & ~cap & (phase == PH_EVEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ds_q   <= 1'b1;
            phase  <= PH_EVEN;
            pend   <= 1'b0;
            pval   <= '0;
            span_q <= span_of('0);
        end else begin
            ds_q  <= ds_n;
            phase <= next_phase(phase, ~frame_n);
            if (cap) begin
                pend <= 1'b1;
                pval <= val_in;
            end else if (apply) begin
                pend <= 1'b0;
            end
            if (apply) begin
                span_q <= span_of(pval);
            end
        end
    end

    assign cmd.apply = apply;
    assign cmd.span  = span_q;

endmodule

// File: rtl/wdl_ptr.sv
module wdl_ptr
    import wdl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  load_cmd_t cmd,
    output ptr_t      ptr
);

    localparam span_t FULL = span_t'(DEPTH);

    addr_t wr_q;
    span_t fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            fill_q <= '0;
        end else begin
            wr_q <= wr_q + addr_t'(1);
            if (cmd.apply) begin
                fill_q <= span_t'(1);
            end else if (fill_q < FULL) begin
                fill_q <= fill_q + span_t'(1);
            end
        end
    end

    // The largest span equals DEPTH; it wraps to the write slot, which is read
    // before it is overwritten.
    assign ptr.wr = wr_q;
    assign ptr.rd = wr_q - cmd.span[AW-1:0];
    assign ptr.ok = (fill_q >= cmd.span) & ~cmd.apply;

endmodule

// File: rtl/wdl_ring.sv
module wdl_ring
    import wdl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ptr_t  ptr,
    input  word_t wdata,
    output word_t rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        mem[ptr.wr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= ptr.ok ? mem[ptr.rd] : '0;
        end
    end

endmodule

// File: rtl/wdl_top.sv
module wdl_top
    import wdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              frame_n,
    input  logic [VAL_W-1:0]  dly_val,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    load_cmd_t cmd;
    ptr_t      ptr;
    logic      cap;
    logic      pend;

    wdl_load_ctl u_load (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .ds_n    (ds_n),
        .frame_n (frame_n),
        .val_in  (dly_val),
        .cap     (cap),
        .pend    (pend),
        .cmd     (cmd)
    );

    wdl_ptr u_ptr (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .ptr (ptr)
    );

    wdl_ring u_ring (
        .clk   (clk),
        .rst   (rst),
        .ptr   (ptr),
        .wdata (din),
        .rdata (dout)
    );

endmodule

// File: rtl/wdl_chk.sv
module wdl_chk
    import wdl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] dout,
    input load_cmd_t         cmd,
    input ptr_t              ptr,
    input logic              cap,
    input logic              pend
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // R1: output cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> dout == '0);

    // R2: applied delay is even and within range
    p_span_legal_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        (cmd.span >= span_t'(2)) && (cmd.span <= span_t'(DEPTH)) && !cmd.span[0]);

    // R3: a capture leaves a setting pending
    p_cap_pending_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        cap |=> pend);

    // R4: delay changes only through an apply
    p_span_hold_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        !cmd.apply |=> $stable(cmd.span));

    // R5: apply edge blanks the output
    p_apply_blank_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        cmd.apply |=> dout == '0);

    // R5: output stays zero while the buffer is short of the delay
    p_fill_blank_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        !ptr.ok |=> dout == '0);

endmodule

bind wdl_top wdl_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .dout (dout),
    .cmd  (cmd),
    .ptr  (ptr),
    .cap  (cap),
    .pend (pend)
);

// File: tb/sim_wdl_top.sv
module sim_wdl_top;
    import wdl_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1;
    logic              ds_n = 1'b1;
    logic              frame_n = 1'b1;
    logic [VAL_W-1:0]  dly_val = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;

    always #2 clk = ~clk;

    wdl_top u0 (
        .clk (clk), .rst (rst), .cs_n (cs_n), .ds_n (ds_n),
        .frame_n (frame_n), .dly_val (dly_val), .din (din), .dout (dout)
    );

    int    vecs = 0;
    int    bad  = 0;
    string req  = "R1";

    // behavioural model state
    int   m = 0;
    int   r = 0;
    int   dcur = 2;
    bit   ds_prev = 1'b1;
    bit   ph = 1'b0;
    bit   pend_m = 1'b0;
    int   pval_m = 0;
    logic [DATA_W-1:0] hist [$];
    logic [DATA_W-1:0] expv;

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: dout=%h expected %h (edge %0d)", tag, act, exp, m);
        end
    endtask

    task automatic step(bit c, bit d, bit f, int v);
        bit capm;
        bit applym;
        cs_n    = c;
        ds_n    = d;
        frame_n = f;
        dly_val = v[VAL_W-1:0];
        din     = DATA_W'((m % 65535) + 1);
        @(posedge clk);
        capm   = ds_prev && !d && !c;
        applym = pend_m && !capm && !ph;
        if (applym) begin
            expv = '0;
            dcur = 2 * pval_m + 2;
            r    = m;
        end else if (m - r >= dcur) begin
            expv = hist[m - dcur];
        end else begin
            expv = '0;
        end
        hist.push_back(din);
        if (capm) begin
            pend_m = 1'b1;
            pval_m = v;
        end else if (applym) begin
            pend_m = 1'b0;
        end
        ph      = f ? ~ph : 1'b0;
        ds_prev = d;
        m++;
        @(negedge clk);
        check(req, dout, expv);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b1, 0);
    endtask

    task automatic load(int v);
        step(1'b0, 1'b1, 1'b1, v);
        step(1'b0, 1'b0, 1'b1, v);
        step(1'b1, 1'b1, 1'b1, v);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", dout, '0);
        rst = 1'b0;

        req = "R1 default delay";
        idle(20);

        req = "R2 setting 2 gives 6";
        load(2);  idle(40);
        req = "R2 setting 0";
        load(0);  idle(30);
        req = "R2 setting 1";
        load(1);  idle(30);
        req = "R2 setting 100";
        load(100); idle(260);

        req = "R3 strobe without select";
        step(1'b1, 1'b1, 1'b1, 9);
        step(1'b1, 1'b0, 1'b1, 9);
        step(1'b1, 1'b1, 1'b1, 9);
        idle(30);
        req = "R3 strobe held low";
        load(3);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 6);
        step(1'b1, 1'b1, 1'b1, 0);
        idle(30);

        req = "R4 frame pulse on capture edge";
        step(1'b0, 1'b1, 1'b1, 4);
        step(1'b0, 1'b0, 1'b0, 4);
        step(1'b1, 1'b1, 1'b1, 4);
        idle(30);
        req = "R4 frame pulse after capture";
        step(1'b0, 1'b1, 1'b1, 5);
        step(1'b0, 1'b0, 1'b1, 5);
        step(1'b1, 1'b1, 1'b0, 5);
        idle(30);

        req = "R6 frame pulses in stream";
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b1, 1'b0, 0);
            idle(2 + (i % 3));
        end

        req = "R8 capture on pending apply";
        step(1'b0, 1'b1, 1'b0, 7);
        step(1'b0, 1'b0, 1'b1, 7);
        step(1'b0, 1'b1, 1'b1, 12);
        step(1'b0, 1'b0, 1'b1, 12);
        step(1'b1, 1'b1, 1'b1, 0);
        idle(60);

        req = "R5 blank after change";
        load(30); idle(100);
        load(1);  idle(20);

        req = "R7 largest setting";
        load(2047); idle(4096 + 100);
        req = "R7 next largest setting";
        load(2046); idle(4094 + 100);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule